// File: doc/BRIEF.md
# System-Management Interrupt Entry and Resume Controller

This block is the control side of a processor core's system-management interrupt handling. A rising edge on the request input is latched. The block acts on it only when the core reports an instruction boundary. It then enters the management state and raises an acknowledge output, which stays high until the handler issues a resume command. On entry it captures the following into a small slot file:
- a status word that describes any trapped I/O instruction;
- a halt-restart flag;
- a cleared I/O-restart slot.

While the block is in the management state, further requests and INIT are blocked. NMI is also blocked until the handler completes its first IRET.

On the resume command the block first checks the rewritten base-address slot.
- If the base is not aligned to 32 KiB, the block enters a shutdown state and stays there.
- Otherwise the base becomes active for the next entry, and the block issues a one-cycle resume decision: continue with the next instruction, re-execute the trapped I/O instruction, or return to the halt state. The halt return also pulses a halt bus-cycle indication.

A debug breakpoint that coincides with the trapped instruction is held back. It is released at resume, or after the re-executed I/O instruction completes if a re-execution was requested. If a second request arrives while a re-execution is pending, it is serviced before the re-execution, and its status word never marks the I/O instruction as valid.

States:
- `ST_RUN` (normal execution). Entry (`ST_RUN` to `ST_SMM`) happens on a boundary with a request pending.
- `ST_SMM` (handler running). Resume (`ST_SMM` to `ST_RUN`) happens on the resume command with an aligned base.
- `ST_SHUT` (shutdown, left only by reset). Shutdown (`ST_SMM` to `ST_SHUT`) happens on the resume command with a misaligned base.

Top module: `smi_resume_ctl`

## Requirements
- R1: A rising edge of `smi_req` is latched as pending. Entry occurs only at a clock where `insn_bnd` is 1 and a request is pending. `smi_ack` is 1 from the clock after entry until the resume clock.
- R2: Rising edges of `smi_req` seen while in the management state are discarded. `init_blocked` and `nmi_blocked` are 1 from entry until the handler's first IRET (`nmi_blocked`) or until resume (`init_blocked`).
- R3: NMI mask. `nmi_taken` sets the mask and `iret_done` clears it. Entry saves the mask and sets it. Inside the management state, `iret_done` clears it. Resume restores the value saved at entry.
- R4: The I/O status word (slot select 0, read-only) is captured at entry. When `io_hit` is 0 the word is zero. Otherwise it holds `io_port` in bits 31:16, `io_str` in bit 15, zeros in bits 14:2, the valid flag in bit 1, and `io_in` in bit 0 (1 = input).
- R5: The restart slot (select 1, bits 15:0) reads 0000h after every entry. At resume, a value of 00FFh yields `resume_kind` 1 (re-execute I/O). Any other value yields 0 (next instruction), unless R6 applies.
- R6: The halt slot (select 2) bit 0 equals `cpu_halted` at entry. At resume, if bit 0 is 1 and R5 did not select re-execution, the block gives `resume_kind` 2 and pulses `halt_cycle` together with `resume_vld`.
- R7: The base slot (select 3) and `smbase` reset to 0003_0000h. At resume, an aligned slot value (bits 14:0 zero) is copied to `smbase`. A misaligned value drives `shutdown` to 1 permanently, drops `smi_ack` and gives no `resume_vld`.
- R8: The revision slot (select 4) always reads 0003_0000h.
- R9: An entry taken while a re-execution is still pending reports bit 1 of the status word as 0.
- R10: A `bp_hit` present at entry produces a one-cycle `dbg_trap`. It comes at resume if no re-execution is pending. Otherwise it comes at the first later boundary that does not cause an entry.
- R11: Slot writes (`wr_en`) take effect only in the management state. Slots 0 and 4 ignore writes, and selects 5 to 7 read zero.
- R12: `resume_vld` is a one-clock pulse on the resume clock, with `resume_kind` 0, 1 or 2 as above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smi_req | input | 1 | Management interrupt request, edge sensitive |
| insn_bnd | input | 1 | Instruction boundary strobe |
| cpu_halted | input | 1 | Core is in the halt state at this boundary |
| io_hit | input | 1 | Boundary follows an I/O instruction that is trapped |
| io_port | input | 16 | Port address of the trapped instruction |
| io_str | input | 1 | Trapped instruction is a string operation |
| io_in | input | 1 | Trapped instruction is an input (1) or an output (0) |
| bp_hit | input | 1 | Debug breakpoint coincides with this boundary |
| nmi_taken | input | 1 | Core accepted an NMI |
| iret_done | input | 1 | An IRET completed |
| rsm_cmd | input | 1 | Resume command from the handler |
| wr_en | input | 1 | Slot write strobe |
| wr_sel | input | 3 | Slot select for the write |
| wr_data | input | 32 | Slot write data |
| rd_sel | input | 3 | Slot select for the read |
| rd_data | output | 32 | Slot read data (combinational) |
| smi_ack | output | 1 | Management state active |
| nmi_blocked | output | 1 | NMI mask |
| init_blocked | output | 1 | INIT blocked |
| smbase | output | 32 | Active base address |
| resume_vld | output | 1 | Resume decision pulse |
| resume_kind | output | 2 | 0 next instruction, 1 re-execute I/O, 2 return to halt |
| halt_cycle | output | 1 | Halt bus-cycle indication pulse |
| dbg_trap | output | 1 | Deferred debug trap pulse |
| shutdown | output | 1 | Shutdown state |

## Verification
A sweep covers every combination of the halted flag, the string, direction and hit flags of the trapped I/O instruction, and whether the handler requests re-execution.

For each combination the bench checks three things:
- the bit positions of the status word;
- the halt flag in the halt slot;
- the priority of I/O re-execution over halt return in the resume decision.

Directed sequences then cover the remaining cases:
- Requests without a boundary show that entry waits for a boundary.
- A request edge raised inside the handler shows that it is discarded.
- IRET and resume orderings separate NMI restore from NMI clear.
- A nested request during a pending re-execution separates the masked valid bit and the deferral of the debug trap.
- Aligned and misaligned base rewrites separate relocation from shutdown.

// File: rtl/smi_pkg.sv
package smi_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_SMM  = 2'd1,
        ST_SHUT = 2'd2
    } smi_state_t;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned IO_PORT_W = 16;
    localparam int unsigned SEL_W     = 3;

    localparam logic [SEL_W-1:0] SEL_IOWORD  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_RESTART = 3'd1;
    localparam logic [SEL_W-1:0] SEL_HALT    = 3'd2;
    localparam logic [SEL_W-1:0] SEL_BASE    = 3'd3;
    localparam logic [SEL_W-1:0] SEL_REV     = 3'd4;

    localparam logic [1:0] KIND_NEXT   = 2'd0;
    localparam logic [1:0] KIND_REEXEC = 2'd1;
    localparam logic [1:0] KIND_HALT   = 2'd2;

    localparam logic [15:0] RESTART_REEXEC = 16'h00FF;
    localparam logic [WORD_W-1:0] REV_WORD = 32'h0003_0000;
endpackage

// File: rtl/smi_edge_latch.sv
module smi_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic mask,
    input  logic clr,
    output logic pend
);
    logic req_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_prev <= 1'b0;
            pend     <= 1'b0;
        end else begin
            req_prev <= req;
            if (clr)
                pend <= 1'b0;
            else if (req && !req_prev && !mask)
                pend <= 1'b1;
        end
    end
endmodule

// File: rtl/smi_nmi_mask.sv
module smi_nmi_mask (
    input  logic clk,
    input  logic rst_n,
    input  logic enter,
    input  logic leave,
    input  logic iret,
    input  logic nmi_taken,
    output logic mask
);
    logic saved;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask  <= 1'b0;
            saved <= 1'b0;
        end else if (enter) begin
            saved <= mask;
            mask  <= 1'b1;
        end else if (leave) begin
            mask <= saved;
        end else if (iret) begin
            mask <= 1'b0;
        end else if (nmi_taken) begin
            mask <= 1'b1;
        end
    end
endmodule

// File: rtl/smi_slot_file.sv
module smi_slot_file
    import smi_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] BASE_RST = 32'h0003_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter,
    input  logic              commit_base,
    input  logic [WORD_W-1:0] io_word_in,
    input  logic              halted_in,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_data,
    output logic [15:0]       restart_val,
    output logic              halt_bit,
    output logic [ADDR_W-1:0] base_slot,
    output logic [ADDR_W-1:0] smbase
);
    logic [WORD_W-1:0] io_word;
    logic [15:0]       halt_slot;

    assign halt_bit = halt_slot[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_word     <= '0;
            restart_val <= '0;
            halt_slot   <= '0;
            base_slot   <= BASE_RST;
            smbase      <= BASE_RST;
        end else if (enter) begin
            io_word     <= io_word_in;
            restart_val <= '0;
            halt_slot   <= {15'd0, halted_in};
            base_slot   <= smbase;
        end else begin
            if (commit_base)
                smbase <= base_slot;
            if (wr_en) begin
                unique case (wr_sel)
                    SEL_RESTART: restart_val <= wr_data[15:0];
                    SEL_HALT:    halt_slot   <= wr_data[15:0];
                    SEL_BASE:    base_slot   <= wr_data[ADDR_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (rd_sel)
            SEL_IOWORD:  rd_data = io_word;
            SEL_RESTART: rd_data = {16'd0, restart_val};
            SEL_HALT:    rd_data = {16'd0, halt_slot};
            SEL_BASE:    rd_data = WORD_W'(base_slot);
            SEL_REV:     rd_data = REV_WORD;
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/smi_resume_ctl.sv
module smi_resume_ctl
    import smi_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned ALIGN_BITS = 15,
    parameter logic [ADDR_W-1:0] BASE_RST = 32'h0003_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smi_req,
    input  logic              insn_bnd,
    input  logic              cpu_halted,
    input  logic              io_hit,
    input  logic [15:0]       io_port,
    input  logic              io_str,
    input  logic              io_in,
    input  logic              bp_hit,
    input  logic              nmi_taken,
    input  logic              iret_done,
    input  logic              rsm_cmd,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [2:0]        rd_sel,
    output logic [31:0]       rd_data,
    output logic              smi_ack,
    output logic              nmi_blocked,
    output logic              init_blocked,
    output logic [ADDR_W-1:0] smbase,
    output logic              resume_vld,
    output logic [1:0]        resume_kind,
    output logic              halt_cycle,
    output logic              dbg_trap,
    output logic              shutdown
);
    localparam int unsigned RESV_W = WORD_W - IO_PORT_W - 3;

    smi_state_t state, state_nx;
    logic pend, enter, resume_ok, go_shut, misalign, want_reexec;
    logic reexec_pend, dbg_def;
    logic [15:0] restart_val;
    logic halt_bit;
    logic [ADDR_W-1:0] base_slot;
    logic [WORD_W-1:0] io_word_new;

    assign misalign    = |base_slot[ALIGN_BITS-1:0];
    assign want_reexec = (restart_val == RESTART_REEXEC);
    assign enter       = (state == ST_RUN) && insn_bnd && pend;
    assign resume_ok   = (state == ST_SMM) && rsm_cmd && !misalign;
    assign go_shut     = (state == ST_SMM) && rsm_cmd && misalign;
    assign io_word_new = io_hit ? {io_port, io_str, {RESV_W{1'b0}},
                                   !reexec_pend, io_in} : '0;

    smi_edge_latch u_edge (
        .clk(clk), .rst_n(rst_n), .req(smi_req),
        .mask(state != ST_RUN), .clr(enter), .pend(pend)
    );

    smi_nmi_mask u_nmi (
        .clk(clk), .rst_n(rst_n), .enter(enter), .leave(resume_ok),
        .iret(iret_done), .nmi_taken(nmi_taken), .mask(nmi_blocked)
    );

    smi_slot_file #(.ADDR_W(ADDR_W), .BASE_RST(BASE_RST)) u_slots (
        .clk(clk), .rst_n(rst_n), .enter(enter), .commit_base(resume_ok),
        .io_word_in(io_word_new), .halted_in(cpu_halted),
        .wr_en(wr_en && (state == ST_SMM)), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .restart_val(restart_val),
        .halt_bit(halt_bit), .base_slot(base_slot), .smbase(smbase)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (enter) state_nx = ST_SMM;
            ST_SMM:  if (go_shut) state_nx = ST_SHUT;
                     else if (resume_ok) state_nx = ST_RUN;
            ST_SHUT: state_nx = ST_SHUT;
            default: state_nx = ST_SHUT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resume_vld  <= 1'b0;
            resume_kind <= KIND_NEXT;
            halt_cycle  <= 1'b0;
            dbg_trap    <= 1'b0;
            reexec_pend <= 1'b0;
            dbg_def     <= 1'b0;
        end else begin
            resume_vld <= 1'b0;
            halt_cycle <= 1'b0;
            dbg_trap   <= 1'b0;
            if (enter) begin
                dbg_def <= dbg_def | bp_hit;
            end else if (resume_ok) begin
                resume_vld <= 1'b1;
                if (want_reexec) begin
                    resume_kind <= KIND_REEXEC;
                    reexec_pend <= 1'b1;
                end else begin
                    resume_kind <= halt_bit ? KIND_HALT : KIND_NEXT;
                    halt_cycle  <= halt_bit;
                    if (!reexec_pend) begin
                        dbg_trap <= dbg_def;
                        dbg_def  <= 1'b0;
                    end
                end
            end else if ((state == ST_RUN) && insn_bnd && reexec_pend) begin
                reexec_pend <= 1'b0;
                dbg_trap    <= dbg_def;
                dbg_def     <= 1'b0;
            end
        end
    end

    assign smi_ack      = (state == ST_SMM);
    assign init_blocked = (state == ST_SMM);
    assign shutdown     = (state == ST_SHUT);
endmodule

// File: rtl/smi_resume_chk.sv
module smi_resume_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       insn_bnd,
    input logic       rsm_cmd,
    input logic       smi_ack,
    input logic       nmi_blocked,
    input logic       init_blocked,
    input logic       resume_vld,
    input logic [1:0] resume_kind,
    input logic       halt_cycle,
    input logic       shutdown
);
    // R1
    entry_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smi_ack) |-> $past(insn_bnd));

    // R2
    entry_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smi_ack) |-> (nmi_blocked && init_blocked));

    // R7
    shutdown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> shutdown);

    // R12
    resume_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_vld |-> ($past(smi_ack) && $past(rsm_cmd) && !smi_ack));

    // R12
    leave_reports_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smi_ack) |-> (resume_vld || shutdown));

    // R6
    halt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_cycle |-> (resume_vld && resume_kind == 2'd2));

    // R12
    kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_vld |-> (resume_kind != 2'd3));
endmodule

bind smi_resume_ctl smi_resume_chk u_chk (
    .clk(clk), .rst_n(rst_n), .insn_bnd(insn_bnd), .rsm_cmd(rsm_cmd),
    .smi_ack(smi_ack), .nmi_blocked(nmi_blocked), .init_blocked(init_blocked),
    .resume_vld(resume_vld), .resume_kind(resume_kind),
    .halt_cycle(halt_cycle), .shutdown(shutdown)
);

// File: tb/sim_smi_resume_ctl.sv
module sim_smi_resume_ctl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic smi_req = 0, insn_bnd = 0, cpu_halted = 0, io_hit = 0;
    logic [15:0] io_port = '0;
    logic io_str = 0, io_in = 0, bp_hit = 0, nmi_taken = 0, iret_done = 0;
    logic rsm_cmd = 0, wr_en = 0;
    logic [2:0] wr_sel = '0, rd_sel = '0;
    logic [31:0] wr_data = '0, rd_data, smbase;
    logic smi_ack, nmi_blocked, init_blocked, resume_vld, halt_cycle, dbg_trap, shutdown;
    logic [1:0] resume_kind;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smi_resume_ctl u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] v);
        rd_sel = sel; #1; v = rd_data;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d; tick(); wr_en = 0;
    endtask

    task automatic enter(input logic h, input logic s, input logic i, input logic hit,
                         input logic [15:0] p, input logic bp);
        smi_req = 1; tick(); smi_req = 0;
        cpu_halted = h; io_str = s; io_in = i; io_hit = hit; io_port = p; bp_hit = bp;
        insn_bnd = 1; tick();
        insn_bnd = 0; cpu_halted = 0; io_str = 0; io_in = 0; io_hit = 0; bp_hit = 0;
    endtask

    task automatic resume();
        rsm_cmd = 1; tick(); rsm_cmd = 0;
    endtask

    task automatic boundary();
        insn_bnd = 1; tick(); insn_bnd = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, expw;
        repeat (3) tick();
        rst_n = 1; tick();

        chk("R1 reset ack", smi_ack, 0);
        chk("R7 reset shutdown", shutdown, 0);
        chk("R7 reset smbase", smbase, 32'h0003_0000);
        chk("R3 reset nmi", nmi_blocked, 0);
        rd(3'd4, v); chk("R8 revision", v, 32'h0003_0000);
        rd(3'd6, v); chk("R11 unused select", v, 0);

        // R1: entry waits for a boundary
        smi_req = 1; tick(); smi_req = 0;
        repeat (3) tick();
        chk("R1 no boundary no entry", smi_ack, 0);
        boundary();
        chk("R1 entry at boundary", smi_ack, 1);
        chk("R2 init blocked", init_blocked, 1);
        repeat (2) tick();
        chk("R1 ack held", smi_ack, 1);
        // R2: edge in handler discarded
        smi_req = 1; tick(); smi_req = 0; tick();
        resume();
        chk("R12 resume pulse", resume_vld, 1);
        chk("R1 ack drops at resume", smi_ack, 0);
        tick();
        chk("R12 pulse one clock", resume_vld, 0);
        boundary();
        chk("R2 masked edge discarded", smi_ack, 0);

        // Sweep: R4 R5 R6
        for (int k = 0; k < 32; k++) begin
            logic h, s, i, hit, rw;
            logic [15:0] p;
            logic [1:0] ek;
            h = k[0]; s = k[1]; i = k[2]; hit = k[3]; rw = k[4];
            p = 16'(16'h1000 + k * 37);
            enter(h, s, i, hit, p, 1'b0);
            chk("R1 sweep entry", smi_ack, 1);
            expw = hit ? {p, s, 13'd0, 1'b1, i} : 32'd0;
            rd(3'd0, v); chk("R4 io status word", v, expw);
            rd(3'd1, v); chk("R5 restart cleared", v, 0);
            rd(3'd2, v); chk("R6 halt flag", v, {31'd0, h});
            wr(3'd0, 32'hFFFF_FFFF);
            rd(3'd0, v); chk("R11 status read-only", v, expw);
            if (rw) wr(3'd1, 32'h0000_00FF);
            resume();
            ek = rw ? 2'd1 : (h ? 2'd2 : 2'd0);
            chk("R5 R6 resume kind", resume_kind, ek);
            chk("R6 halt cycle", halt_cycle, (!rw && h));
            chk("R12 resume pulse", resume_vld, 1);
            tick();
            if (rw) begin
                boundary();
                chk("R10 no trap without breakpoint", dbg_trap, 0);
            end
        end

        // R6: handler clears halt flag
        enter(1, 0, 0, 0, 16'h0, 0);
        wr(3'd2, 32'h0);
        resume();
        chk("R6 halt flag cleared", resume_kind, 0);
        chk("R6 no halt cycle", halt_cycle, 0);
        tick();

        // R5: value other than 00FF
        enter(0, 0, 0, 1, 16'h55, 0);
        wr(3'd1, 32'h0000_00FE);
        resume();
        chk("R5 other value next", resume_kind, 0);
        tick();

        // R3: NMI mask
        nmi_taken = 1; tick(); nmi_taken = 0;
        chk("R3 nmi taken", nmi_blocked, 1);
        enter(0, 0, 0, 0, 16'h0, 0);
        chk("R3 blocked in handler", nmi_blocked, 1);
        iret_done = 1; tick(); iret_done = 0;
        chk("R3 iret unmasks", nmi_blocked, 0);
        resume();
        chk("R3 restored set", nmi_blocked, 1);
        iret_done = 1; tick(); iret_done = 0;
        chk("R3 iret outside", nmi_blocked, 0);
        enter(0, 0, 0, 0, 16'h0, 0);
        chk("R2 nmi blocked entry", nmi_blocked, 1);
        resume();
        chk("R3 restored clear", nmi_blocked, 0);
        tick();

        // R10: breakpoint without restart
        enter(0, 0, 1, 1, 16'h60, 1);
        resume();
        chk("R10 trap at resume", dbg_trap, 1);
        tick();
        chk("R10 trap one clock", dbg_trap, 0);

        // R10 R9: restart pending, nested entry
        enter(0, 0, 1, 1, 16'h64, 1);
        wr(3'd1, 32'h0000_00FF);
        resume();
        chk("R5 reexec", resume_kind, 1);
        chk("R10 deferred past resume", dbg_trap, 0);
        tick();
        enter(0, 0, 1, 1, 16'h64, 0);
        chk("R9 nested entry", smi_ack, 1);
        rd(3'd0, v); chk("R9 valid bit clear", v, {16'h64, 1'b0, 13'd0, 1'b0, 1'b1});
        rd(3'd1, v); chk("R5 nested restart cleared", v, 0);
        resume();
        chk("R9 nested kind", resume_kind, 0);
        chk("R10 still deferred", dbg_trap, 0);
        tick();
        boundary();
        chk("R10 trap after reexec", dbg_trap, 1);
        tick();
        chk("R10 trap cleared", dbg_trap, 0);

        // R7 R11: base relocation
        wr(3'd3, 32'h0010_8000);
        rd(3'd3, v); chk("R11 write outside ignored", v, 32'h0003_0000);
        enter(0, 0, 0, 0, 16'h0, 0);
        rd(3'd3, v); chk("R7 base slot", v, 32'h0003_0000);
        wr(3'd3, 32'h0010_8000);
        wr(3'd4, 32'h1234_5678);
        rd(3'd4, v); chk("R8 revision read-only", v, 32'h0003_0000);
        resume();
        chk("R7 relocated", smbase, 32'h0010_8000);
        tick();
        enter(0, 0, 0, 0, 16'h0, 0);
        rd(3'd3, v); chk("R7 new base seen", v, 32'h0010_8000);
        wr(3'd3, 32'h0010_4000);
        resume();
        chk("R7 misaligned shutdown", shutdown, 1);
        chk("R7 no resume pulse", resume_vld, 0);
        chk("R7 ack dropped", smi_ack, 0);
        chk("R7 base kept", smbase, 32'h0010_8000);
        tick();
        enter(0, 0, 0, 0, 16'h0, 0);
        chk("R7 shutdown sticky", shutdown, 1);
        chk("R7 no entry in shutdown", smi_ack, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule